// File: doc/BRIEF.md
# Super I/O Configuration Unlock Controller

This block is the configuration front end of a multi-function PC I/O controller. It watches byte-wide I/O writes and reads on a small group of ports. A key-sequence state machine decides when software may reach the configuration space. While the space is open, software writes an index and then reads or writes the selected entry of a 256-byte configuration register file. The logical devices that use these registers sit outside this block. They see the registers through a side read port, and they see every accepted change through a one-cycle change strobe.

There are two port maps. In the standard map, a key port at 0x250 opens and closes the space with one write, an index port sits at 0x251 and a data port at 0x252. In the alternate map, the index port at 0x3F0 also takes the key, which must be written twice in a row, and the data port is at 0x3F1. Register 0x16 bit 0 selects the map. Register 0x0C bit 5 modifies the key. Register 0x09 bit 6 is a read/write lock. Two registers have side effects on write: a preset load driven by register 0x16 bit 1, and nibble fill-in on register 0x28.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: After reset, registers 0x03=0x30, 0x07=0xF5, 0x0A=0x1F, 0x0C=0x28 and 0x0D=0xA3, and every other register is 0x00. The space is closed, io_ack, chg_vld and cfg_active are low, and io_rdata is 0xFF. The standard map is active with key 0x89.
- R2: In the standard map, a write of the key to 0x250 opens the space. A write of any other value to 0x250 closes it.
- R3: In the alternate map, the key is 0x86 ORed with register 0x0C bit 5. Two consecutive key writes to 0x3F0 open the space. A non-key write to 0x3F0 while the space is closed discards a pending first key. Reads do not affect the count.
- R4: In the alternate map with the space open, a write to 0x3F0 loads the index. If the value is 0xAA, the write also closes the space.
- R5: While the space is closed, a read of any mapped port returns 0xFF. While it is open, the index port returns the index and the data port returns the indexed register.
- R6: Data-port writes while the space is closed change no register and raise no change strobe.
- R7: While register 0x09 bit 6 is 1, every data-port write is ignored. Data-port reads of indexes below 0x18 return 0xFF, and reads of indexes at or above 0x18 return the register.
- R8: A write that changes register 0x16 bit 1 to 1 loads 0x1E=0x81 and 0x20..0x29 = FC,7C,FD,DE,FE,BE,23,65,43,62. A write that changes it to 0 clears those registers. A write that leaves the bit unchanged leaves them as they are.
- R9: A write to register 0x28 that changes its low nibble to 0 stores 3 in that nibble. A write that changes its high nibble to 0 stores 4 in that nibble. A nibble that is already 0 and is written with 0 stays 0.
- R10: The clock edge that accepts a data write raises chg_vld for exactly one cycle. In that cycle chg_idx carries the index and chg_xor carries old XOR stored value.
- R11: io_ack is high in the cycle after a read or write strobe whose address is in the current map. A strobe to any other address gets no ack and has no effect. io_rdata holds the read result while io_ack is high.
- R12: A write that changes register 0x16 bit 0 or register 0x0C bit 5 takes effect from the next bus cycle and leaves the open/closed state as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle (ignored if io_wr is also high) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid with io_ack |
| io_ack | output | 1 | Bus acknowledge for a mapped port |
| cfg_active | output | 1 | Configuration space open |
| cfg_sel | input | 8 | Side read port index |
| cfg_q | output | 8 | Side read port data (combinational) |
| chg_vld | output | 1 | Register changed strobe |
| chg_idx | output | 8 | Index of the written register |
| chg_xor | output | 8 | Bits changed by the write |

## Verification
The bench goes after the two-write key sequence. It places a stray non-key write between two keys and a read between two keys. A design that keeps a stale first key would open too early, and one that counts reads would open or fail in the wrong place. It writes register 0x28 so that one nibble goes to zero and the other was already zero, which catches a fill-in that ignores whether the nibble changed. It also checks that a rewrite of register 0x16 with bit 1 unchanged keeps a hand-edited preset register, and that the lock hides only low indexes while blocking every write, so a design with the wrong boundary or an unlocked high range shows a wrong value.

// File: rtl/cfg_unlock_pkg.sv
// Package: shared constants, port kinds and reset/preset tables for the
// configuration unlock controller. Assumes 8-bit data and 256 registers.
package cfg_unlock_pkg;

    localparam int CFG_DW    = 8;
    localparam int REG_CNT   = 256;
    localparam int IDX_W     = $clog2(REG_CNT);

    // Registers whose contents steer this block
    localparam logic [IDX_W-1:0] IDX_LOCK     = 8'h09;
    localparam logic [IDX_W-1:0] IDX_KEYMOD   = 8'h0C;
    localparam logic [IDX_W-1:0] IDX_PORTCFG  = 8'h16;
    localparam logic [IDX_W-1:0] IDX_IRQSEL   = 8'h28;
    localparam logic [IDX_W-1:0] IDX_PRE_LAST = 8'h29;
    localparam logic [IDX_W-1:0] IDX_PRE_HEAD = 8'h1E;
    localparam logic [IDX_W-1:0] LOCK_LIMIT   = 8'h18;

    localparam int BIT_ALTMAP = 0;
    localparam int BIT_PRESET = 1;
    localparam int BIT_KEYMOD = 5;
    localparam int BIT_RWLOCK = 6;

    localparam logic [CFG_DW-1:0] KEY_ALT_BASE = 8'h86;
    localparam logic [CFG_DW-1:0] KEY_STD_BASE = 8'h88;
    localparam logic [CFG_DW-1:0] EXIT_CODE    = 8'hAA;
    localparam logic [CFG_DW-1:0] IDLE_READ    = 8'hFF;
    localparam logic [3:0]        FILL_LO      = 4'h3;
    localparam logic [3:0]        FILL_HI      = 4'h4;

    typedef enum logic [1:0] {
        PORT_NONE,
        PORT_KEY,
        PORT_INDEX,
        PORT_DATA
    } port_kind_e;

    // Reset value of register i
    function automatic logic [CFG_DW-1:0] reset_value(input int unsigned i);
        case (i)
            32'h03:  return 8'h30;
            32'h07:  return 8'hF5;
            32'h0A:  return 8'h1F;
            32'h0C:  return 8'h28;
            32'h0D:  return 8'hA3;
            default: return 8'h00;
        endcase
    endfunction

    // True for the registers touched by the preset load
    function automatic logic preset_member(input int unsigned i);
        return (i == 32'h1E) || ((i >= 32'h20) && (i <= 32'h29));
    endfunction

    // Preset value of register i
    function automatic logic [CFG_DW-1:0] preset_value(input int unsigned i);
        case (i)
            32'h1E:  return 8'h81;
            32'h20:  return 8'hFC;
            32'h21:  return 8'h7C;
            32'h22:  return 8'hFD;
            32'h23:  return 8'hDE;
            32'h24:  return 8'hFE;
            32'h25:  return 8'hBE;
            32'h26:  return 8'h23;
            32'h27:  return 8'h65;
            32'h28:  return 8'h43;
            32'h29:  return 8'h62;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_port_dec.sv
// Port decoder: classifies the bus address against the active port map
// and forms the entry key. Purely combinational.
// Assumes the two maps do not overlap.
module cfg_port_dec
    import cfg_unlock_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]  STD_BASE = 16'h0250,
    parameter logic [ADDR_W-1:0]  ALT_BASE = 16'h03F0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              alt_map,
    input  logic              key_mod,
    output port_kind_e        kind,
    output logic [CFG_DW-1:0] key_value,
    output logic              two_step
);

    localparam logic [ADDR_W-1:0] STD_KEY  = STD_BASE;
    localparam logic [ADDR_W-1:0] STD_IDX  = STD_BASE + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STD_DATA = STD_BASE + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ALT_IDX  = ALT_BASE;
    localparam logic [ADDR_W-1:0] ALT_DATA = ALT_BASE + ADDR_W'(1);

    // Address classification for the selected map
    always_comb begin
        kind = PORT_NONE;
        if (alt_map) begin
            if (addr == ALT_IDX)       kind = PORT_INDEX;
            else if (addr == ALT_DATA) kind = PORT_DATA;
        end else begin
            if (addr == STD_KEY)       kind = PORT_KEY;
            else if (addr == STD_IDX)  kind = PORT_INDEX;
            else if (addr == STD_DATA) kind = PORT_DATA;
        end
    end

    // Key value and number of key writes for the selected map
    always_comb begin
        key_value = (alt_map ? KEY_ALT_BASE : KEY_STD_BASE) | {7'd0, key_mod};
        two_step  = alt_map;
    end

endmodule

// File: rtl/cfg_key_fsm.sv
// Key sequencer: tracks whether the configuration space is open,
// counts the pending first key in two-write mode and holds the index.
// Assumes one bus write per strobe and that the decoder marks ports.
module cfg_key_fsm
    import cfg_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  port_kind_e        kind,
    input  logic [CFG_DW-1:0] wdata,
    input  logic [CFG_DW-1:0] key_value,
    input  logic              two_step,
    output logic              cfg_open,
    output logic [IDX_W-1:0]  index
);

    logic first_key;
    logic is_key;

    // Key match on the incoming data
    always_comb is_key = (wdata == key_value);

    // Open/closed state, pending key and index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_open  <= 1'b0;
            first_key <= 1'b0;
            index     <= '0;
        end else if (wr_stb) begin
            case (kind)
                PORT_KEY: cfg_open <= is_key;
                PORT_INDEX: begin
                    if (!two_step) begin
                        index <= wdata;
                    end else if (is_key && !cfg_open) begin
                        if (first_key) begin
                            cfg_open  <= 1'b1;
                            first_key <= 1'b0;
                        end else begin
                            first_key <= 1'b1;
                        end
                    end else if (cfg_open) begin
                        index <= wdata;
                        if (wdata == EXIT_CODE) cfg_open <= 1'b0;
                    end else begin
                        first_key <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: a wrong value on the key port leaves the space closed
    p_key_port_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && kind == PORT_KEY && wdata != key_value) |=> !cfg_open);

    // R3: a lone first key never opens the space
    p_first_key_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && kind == PORT_INDEX && two_step && !cfg_open && is_key && !first_key)
        |=> !cfg_open);

    // R4: the exit code closes the space and lands in the index
    p_exit_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && kind == PORT_INDEX && two_step && cfg_open && wdata == EXIT_CODE)
        |=> (!cfg_open && index == EXIT_CODE));

endmodule

// File: rtl/cfg_regfile.sv
// Configuration register file: reset defaults, indexed writes with the
// nibble fill-in, preset load on a flip of the preset bit, and two read
// ports. Assumes at most one write per cycle.
module cfg_regfile
    import cfg_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CFG_DW-1:0] wr_data,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [IDX_W-1:0]  side_idx,
    output logic [CFG_DW-1:0] bus_q,
    output logic [CFG_DW-1:0] side_q,
    output logic [CFG_DW-1:0] wr_old,
    output logic [CFG_DW-1:0] wr_final,
    output logic              alt_map,
    output logic              key_mod,
    output logic              rw_lock
);

    logic [CFG_DW-1:0] mem [REG_CNT];
    logic              preset_fire;
    logic              preset_on;
    logic              fill_lo;
    logic              fill_hi;

    // Old value and final stored value with the nibble fill-in
    always_comb begin
        wr_old   = mem[wr_idx];
        fill_lo  = (wr_idx == IDX_IRQSEL) && (wr_data[3:0] != wr_old[3:0])
                   && (wr_data[3:0] == 4'h0);
        fill_hi  = (wr_idx == IDX_IRQSEL) && (wr_data[7:4] != wr_old[7:4])
                   && (wr_data[7:4] == 4'h0);
        wr_final = {fill_hi ? FILL_HI : wr_data[7:4],
                    fill_lo ? FILL_LO : wr_data[3:0]};
    end

    // Preset trigger: the preset bit of the port config register flips
    always_comb begin
        preset_on   = wr_data[BIT_PRESET];
        preset_fire = wr_en && (wr_idx == IDX_PORTCFG)
                      && (wr_data[BIT_PRESET] != mem[IDX_PORTCFG][BIT_PRESET]);
    end

    // Storage update: reset defaults, direct write, then preset load
    always_ff @(posedge clk) begin
        for (int j = 0; j < REG_CNT; j++) begin
            if (!rst_n) begin
                mem[j] <= reset_value(j);
            end else if (wr_en && (wr_idx == IDX_W'(j))) begin
                mem[j] <= wr_final;
            end else if (preset_fire && preset_member(j)) begin
                mem[j] <= preset_on ? preset_value(j) : '0;
            end
        end
    end

    // Read ports and control bits
    always_comb begin
        bus_q   = mem[bus_idx];
        side_q  = mem[side_idx];
        alt_map = mem[IDX_PORTCFG][BIT_ALTMAP];
        key_mod = mem[IDX_KEYMOD][BIT_KEYMOD];
        rw_lock = mem[IDX_LOCK][BIT_RWLOCK];
    end

    // R9: a low nibble changed to zero is stored as the fill value
    p_fill_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_IRQSEL && wr_data[3:0] != mem[IDX_IRQSEL][3:0])
        |=> (mem[IDX_IRQSEL][3:0] != 4'h0));

    // R9: a high nibble changed to zero is stored as the fill value
    p_fill_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_IRQSEL && wr_data[7:4] != mem[IDX_IRQSEL][7:4])
        |=> (mem[IDX_IRQSEL][7:4] != 4'h0));

    // R8: setting the preset bit loads the preset range
    p_preset_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_PORTCFG && wr_data[BIT_PRESET] && !mem[IDX_PORTCFG][BIT_PRESET])
        |=> (mem[IDX_PRE_LAST] == 8'h62 && mem[IDX_PRE_HEAD] == 8'h81));

    // R8: clearing the preset bit clears the preset range
    p_preset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_PORTCFG && !wr_data[BIT_PRESET] && mem[IDX_PORTCFG][BIT_PRESET])
        |=> (mem[IDX_PRE_LAST] == 8'h00 && mem[IDX_PRE_HEAD] == 8'h00));

endmodule

// File: rtl/cfg_unlock_ctrl.sv
// Top: configuration unlock controller. Decodes the bus, runs the key
// sequencer, gates data access by the open state and the lock bit, and
// registers the ack, read data and change strobe.
// Assumes one-cycle io_wr/io_rd strobes; io_wr wins if both are high.
module cfg_unlock_ctrl
    import cfg_unlock_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] STD_BASE = 16'h0250,
    parameter logic [ADDR_W-1:0] ALT_BASE = 16'h03F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_ack,
    output logic              cfg_active,
    input  logic [7:0]        cfg_sel,
    output logic [7:0]        cfg_q,
    output logic              chg_vld,
    output logic [7:0]        chg_idx,
    output logic [7:0]        chg_xor
);

    port_kind_e        kind;
    logic [CFG_DW-1:0] key_value;
    logic              two_step;
    logic              alt_map;
    logic              key_mod;
    logic              rw_lock;
    logic              cfg_open;
    logic [IDX_W-1:0]  index;
    logic [CFG_DW-1:0] bus_q;
    logic [CFG_DW-1:0] wr_old;
    logic [CFG_DW-1:0] wr_final;
    logic              hit;
    logic              rd_stb;
    logic              data_accept;
    logic [CFG_DW-1:0] rd_val;

    cfg_port_dec #(
        .ADDR_W   (ADDR_W),
        .STD_BASE (STD_BASE),
        .ALT_BASE (ALT_BASE)
    ) u_dec (
        .addr      (io_addr),
        .alt_map   (alt_map),
        .key_mod   (key_mod),
        .kind      (kind),
        .key_value (key_value),
        .two_step  (two_step)
    );

    cfg_key_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (io_wr),
        .kind      (kind),
        .wdata     (io_wdata),
        .key_value (key_value),
        .two_step  (two_step),
        .cfg_open  (cfg_open),
        .index     (index)
    );

    cfg_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_accept),
        .wr_idx   (index),
        .wr_data  (io_wdata),
        .bus_idx  (index),
        .side_idx (cfg_sel),
        .bus_q    (bus_q),
        .side_q   (cfg_q),
        .wr_old   (wr_old),
        .wr_final (wr_final),
        .alt_map  (alt_map),
        .key_mod  (key_mod),
        .rw_lock  (rw_lock)
    );

    // Bus qualification and data-write acceptance
    always_comb begin
        hit         = (kind != PORT_NONE);
        rd_stb      = io_rd && !io_wr && hit;
        data_accept = io_wr && (kind == PORT_DATA) && cfg_open && !rw_lock;
    end

    // Read data selection for the addressed port
    always_comb begin
        rd_val = IDLE_READ;
        if (cfg_open) begin
            if (kind == PORT_INDEX) begin
                rd_val = index;
            end else if (kind == PORT_DATA) begin
                rd_val = (rw_lock && (index < LOCK_LIMIT)) ? IDLE_READ : bus_q;
            end
        end
    end

    // Registered ack, read data and change strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_ack   <= 1'b0;
            io_rdata <= IDLE_READ;
            chg_vld  <= 1'b0;
            chg_idx  <= '0;
            chg_xor  <= '0;
        end else begin
            io_ack  <= (io_wr || io_rd) && hit;
            if (rd_stb) io_rdata <= rd_val;
            chg_vld <= data_accept;
            if (data_accept) begin
                chg_idx <= index;
                chg_xor <= wr_old ^ wr_final;
            end
        end
    end

    always_comb cfg_active = cfg_open;

    // R11: strobes outside the active map are not acknowledged
    p_no_ack_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && kind == PORT_NONE) |=> !io_ack);

    // R5: a closed space reads as all ones
    p_closed_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && hit && !cfg_open) |=> (io_rdata == IDLE_READ));

    // R6: no change strobe follows a write while closed
    p_closed_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !cfg_open) |=> !chg_vld);

    // R7: the lock hides low registers and blocks writes
    p_lock_low_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && kind == PORT_DATA && rw_lock && index < LOCK_LIMIT)
        |=> (io_rdata == IDLE_READ));

    p_lock_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && rw_lock) |=> !chg_vld);

    // R10: the strobe follows an accepted write with its index
    p_strobe_index_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && kind == PORT_DATA && cfg_open && !rw_lock)
        |=> (chg_vld && chg_idx == $past(index)));

endmodule

// File: tb/tb_cfg_unlock_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_unlock_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] io_addr;
    logic        io_wr, io_rd;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic        io_ack, cfg_active;
    logic [7:0]  cfg_sel, cfg_q;
    logic        chg_vld;
    logic [7:0]  chg_idx, chg_xor;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit        rd;
        bit        ack;
        logic [7:0] data;
        bit        chg;
        logic [7:0] idx;
        logic [7:0] xr;
        string     tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    cfg_unlock_ctrl dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
        .cfg_active(cfg_active), .cfg_sel(cfg_sel), .cfg_q(cfg_q),
        .chg_vld(chg_vld), .chg_idx(chg_idx), .chg_xor(chg_xor)
    );

    // Scoreboard monitor: one expectation per driven cycle
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (sb.size() != 0) begin
                e = sb.pop_front();
                checks++;
                if (io_ack !== e.ack || chg_vld !== e.chg
                    || (e.rd && e.ack && io_rdata !== e.data)
                    || (e.chg && (chg_idx !== e.idx || chg_xor !== e.xr))) begin
                    errors++;
                    $display("FAIL %s: ack=%0b rdata=%h chg=%0b idx=%h xor=%h expected ack=%0b rdata=%h chg=%0b idx=%h xor=%h",
                             e.tag, io_ack, io_rdata, chg_vld, chg_idx, chg_xor,
                             e.ack, e.data, e.chg, e.idx, e.xr);
                end
            end
        end
    end

    task automatic push(bit rd, bit ack, logic [7:0] data, bit chg,
                        logic [7:0] idx, logic [7:0] xr, string tag);
        exp_t e;
        e.rd = rd; e.ack = ack; e.data = data; e.chg = chg;
        e.idx = idx; e.xr = xr; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic bus_wr(logic [15:0] a, logic [7:0] d, bit ack, bit chg,
                          logic [7:0] idx, logic [7:0] xr, string tag);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        push(1'b0, ack, 8'h00, chg, idx, xr, tag);
    endtask

    task automatic bus_rd(logic [15:0] a, bit ack, logic [7:0] d, string tag);
        @(negedge clk);
        io_addr = a; io_wr = 1'b0; io_rd = 1'b1;
        push(1'b1, ack, d, 1'b0, 8'h00, 8'h00, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        push(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "idle");
    endtask

    task automatic peek(logic [7:0] sel, logic [7:0] exp, string tag);
        idle();
        cfg_sel = sel;
        #1;
        checks++;
        if (cfg_q !== exp) begin
            errors++;
            $display("FAIL %s: reg %h actual %h expected %h", tag, sel, cfg_q, exp);
        end
    endtask

    task automatic direct(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0;
        io_wdata = '0; cfg_sel = '0;
        repeat (4) @(negedge clk);
        // R1: reset state of outputs
        direct(io_ack == 1'b0 && chg_vld == 1'b0 && cfg_active == 1'b0,
               "R1 outputs", {io_ack, chg_vld, cfg_active, 5'd0}, 8'h00);
        direct(io_rdata == 8'hFF, "R1 rdata", io_rdata, 8'hFF);
        rst_n = 1'b1;

        // R1: default register contents
        peek(8'h03, 8'h30, "R1 reg03");
        peek(8'h07, 8'hF5, "R1 reg07");
        peek(8'h0A, 8'h1F, "R1 reg0A");
        peek(8'h0C, 8'h28, "R1 reg0C");
        peek(8'h0D, 8'hA3, "R1 reg0D");
        peek(8'h16, 8'h00, "R1 reg16");
        peek(8'h28, 8'h00, "R1 reg28");

        // R5/R6/R11: closed space and unmapped ports
        bus_rd(16'h0251, 1'b1, 8'hFF, "R5 closed index read");
        bus_wr(16'h0252, 8'h55, 1'b1, 1'b0, 8'h00, 8'h00, "R6 closed data write");
        peek(8'h00, 8'h00, "R6 reg00 untouched");
        bus_wr(16'h03F0, 8'h87, 1'b0, 1'b0, 8'h00, 8'h00, "R11 unmapped write");
        bus_rd(16'h0123, 1'b0, 8'hFF, "R11 unmapped read");

        // R2: single-write key in the standard map
        bus_wr(16'h0250, 8'h88, 1'b1, 1'b0, 8'h00, 8'h00, "R2 wrong key");
        bus_rd(16'h0251, 1'b1, 8'hFF, "R2 still closed");
        bus_wr(16'h0250, 8'h89, 1'b1, 1'b0, 8'h00, 8'h00, "R2 key");
        bus_rd(16'h0251, 1'b1, 8'h00, "R5 index read");

        // R10/R5: data write and strobe
        bus_wr(16'h0251, 8'h20, 1'b1, 1'b0, 8'h00, 8'h00, "R5 index set");
        bus_wr(16'h0252, 8'h5A, 1'b1, 1'b1, 8'h20, 8'h5A, "R10 first write");
        bus_rd(16'h0252, 1'b1, 8'h5A, "R5 data read");
        bus_wr(16'h0252, 8'h5A, 1'b1, 1'b1, 8'h20, 8'h00, "R10 same value");

        // R9: nibble fill-in
        bus_wr(16'h0251, 8'h28, 1'b1, 1'b0, 8'h00, 8'h00, "R9 index");
        bus_wr(16'h0252, 8'h50, 1'b1, 1'b1, 8'h28, 8'h50, "R9 zero stays zero");
        bus_rd(16'h0252, 1'b1, 8'h50, "R9 read 50");
        bus_wr(16'h0252, 8'h07, 1'b1, 1'b1, 8'h28, 8'h17, "R9 high fill");
        bus_rd(16'h0252, 1'b1, 8'h47, "R9 read 47");
        bus_wr(16'h0252, 8'h40, 1'b1, 1'b1, 8'h28, 8'h04, "R9 low fill");
        bus_rd(16'h0252, 1'b1, 8'h43, "R9 read 43");

        // R8: preset load, hold and clear
        bus_wr(16'h0251, 8'h16, 1'b1, 1'b0, 8'h00, 8'h00, "R8 index");
        bus_wr(16'h0252, 8'h02, 1'b1, 1'b1, 8'h16, 8'h02, "R8 set preset bit");
        peek(8'h1E, 8'h81, "R8 reg1E");
        peek(8'h20, 8'hFC, "R8 reg20");
        peek(8'h24, 8'hFE, "R8 reg24");
        peek(8'h27, 8'h65, "R8 reg27");
        peek(8'h29, 8'h62, "R8 reg29");
        peek(8'h1F, 8'h00, "R8 reg1F outside");
        bus_wr(16'h0251, 8'h20, 1'b1, 1'b0, 8'h00, 8'h00, "R8 index 20");
        bus_wr(16'h0252, 8'h11, 1'b1, 1'b1, 8'h20, 8'hED, "R8 edit reg20");
        bus_wr(16'h0251, 8'h16, 1'b1, 1'b0, 8'h00, 8'h00, "R8 index 16");
        bus_wr(16'h0252, 8'h02, 1'b1, 1'b1, 8'h16, 8'h00, "R8 rewrite same bit");
        peek(8'h20, 8'h11, "R8 no reload");
        bus_wr(16'h0252, 8'h00, 1'b1, 1'b1, 8'h16, 8'h02, "R8 clear preset bit");
        peek(8'h20, 8'h00, "R8 reg20 cleared");
        peek(8'h29, 8'h00, "R8 reg29 cleared");
        peek(8'h1E, 8'h00, "R8 reg1E cleared");

        // R2: any other value on the key port closes
        bus_wr(16'h0250, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, "R2 close");
        bus_rd(16'h0252, 1'b1, 8'hFF, "R2 closed data read");

        // R12: switch to the alternate map while open
        bus_wr(16'h0250, 8'h89, 1'b1, 1'b0, 8'h00, 8'h00, "R12 reopen");
        bus_wr(16'h0252, 8'h01, 1'b1, 1'b1, 8'h16, 8'h01, "R12 select alt map");
        bus_rd(16'h0251, 1'b0, 8'hFF, "R12 old port silent");
        bus_rd(16'h03F0, 1'b1, 8'h16, "R12 new index port open");
        bus_rd(16'h03F1, 1'b1, 8'h01, "R12 new data port");

        // R4: exit code
        bus_wr(16'h03F0, 8'hAA, 1'b1, 1'b0, 8'h00, 8'h00, "R4 exit");
        bus_rd(16'h03F0, 1'b1, 8'hFF, "R4 closed index");
        bus_rd(16'h03F1, 1'b1, 8'hFF, "R4 closed data");
        bus_wr(16'h03F1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, "R6 closed alt write");

        // R3: two-write key with interruption
        bus_wr(16'h03F0, 8'h87, 1'b1, 1'b0, 8'h00, 8'h00, "R3 first key");
        bus_wr(16'h03F0, 8'h11, 1'b1, 1'b0, 8'h00, 8'h00, "R3 stray write");
        bus_wr(16'h03F0, 8'h87, 1'b1, 1'b0, 8'h00, 8'h00, "R3 key again");
        bus_rd(16'h03F0, 1'b1, 8'hFF, "R3 not yet open");
        bus_wr(16'h03F0, 8'h87, 1'b1, 1'b0, 8'h00, 8'h00, "R3 second key");
        bus_rd(16'h03F0, 1'b1, 8'hAA, "R3 open index");

        // R3/R12: key modifier cleared gives key 0x86
        bus_wr(16'h03F0, 8'h0C, 1'b1, 1'b0, 8'h00, 8'h00, "R12 index 0C");
        bus_wr(16'h03F1, 8'h08, 1'b1, 1'b1, 8'h0C, 8'h20, "R12 clear key bit");
        bus_wr(16'h03F0, 8'hAA, 1'b1, 1'b0, 8'h00, 8'h00, "R4 exit again");
        bus_wr(16'h03F0, 8'h87, 1'b1, 1'b0, 8'h00, 8'h00, "R3 old key 1");
        bus_wr(16'h03F0, 8'h87, 1'b1, 1'b0, 8'h00, 8'h00, "R3 old key 2");
        bus_rd(16'h03F0, 1'b1, 8'hFF, "R3 old key rejected");
        bus_wr(16'h03F0, 8'h86, 1'b1, 1'b0, 8'h00, 8'h00, "R3 new key 1");
        bus_wr(16'h03F0, 8'h86, 1'b1, 1'b0, 8'h00, 8'h00, "R3 new key 2");
        bus_rd(16'h03F0, 1'b1, 8'hAA, "R3 new key opens");

        // R7: lock bit
        bus_wr(16'h03F0, 8'h30, 1'b1, 1'b0, 8'h00, 8'h00, "R7 index 30");
        bus_wr(16'h03F1, 8'h3C, 1'b1, 1'b1, 8'h30, 8'h3C, "R7 write 30");
        bus_wr(16'h03F0, 8'h09, 1'b1, 1'b0, 8'h00, 8'h00, "R7 index 09");
        bus_wr(16'h03F1, 8'h40, 1'b1, 1'b1, 8'h09, 8'h40, "R7 set lock");
        bus_rd(16'h03F1, 1'b1, 8'hFF, "R7 low read hidden");
        bus_wr(16'h03F1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, "R7 low write blocked");
        bus_wr(16'h03F0, 8'h30, 1'b1, 1'b0, 8'h00, 8'h00, "R7 index 30 again");
        bus_rd(16'h03F1, 1'b1, 8'h3C, "R7 high read visible");
        bus_wr(16'h03F1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, "R7 high write blocked");
        bus_rd(16'h03F1, 1'b1, 8'h3C, "R7 high unchanged");
        bus_rd(16'h03F0, 1'b1, 8'h30, "R7 index read");
        peek(8'h09, 8'h40, "R7 lock stays");
        peek(8'h30, 8'h3C, "R7 reg30 kept");

        idle();
        idle();
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule